// File: doc/BRIEF.md
# Display Control Word Decoder

This block sits behind the display control port of a graphics unit. Every 32-bit word written to the port carries an opcode in its top byte; the block decodes that opcode and turns the rest of the word into changes of a 32-bit status word, of a set of display geometry registers (scan-out origin, horizontal and vertical display window) and of a readback register that software fetches after an information request. It also raises one-cycle pulses: one that tells the downstream command framer to drop its partial state, and one that tells the scan-out logic that something visible changed.

A second write port carries draw-setting words from the drawing command stream into eight auxiliary registers, which the information requests can read back in masked form. A write of the same value that is already held for a given opcode is filtered out, so repeated identical control writes cost nothing downstream.

Top module: `disp_ctrl_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, the status word becomes 0x14802000, the readback word, all geometry fields and both pulses become 0, and auxiliary register i takes the value (0xE0+i)<<24.
- R2: A control write with opcode 0x00 (bits [31:24]) puts the status, readback, geometry and auxiliary registers back into the R1 state and raises both `disp_dirty_o` and `framer_clr_o` for one cycle.
- R3: Opcode 0x01 raises `framer_clr_o` for the single cycle after the write and changes no status, geometry or readback value.
- R4: Opcode 0x03 copies data bit 0 into status bit 23 (display blanked).
- R5: Opcode 0x04 copies data bits [1:0] into status bits [30:29] (transfer direction).
- R6: Opcode 0x05 loads the scan-out origin: X from data bits [9:0], Y from data bits [18:10].
- R7: Opcode 0x06 loads the horizontal window start from bits [11:0] and end from bits [23:12]; opcode 0x07 loads the vertical start from bits [9:0] and end from bits [19:10].
- R8: Opcode 0x08 writes data bits [5:0] into status bits [22:17] and data bit 6 into status bit 16; other status bits keep their value.
- R9: Opcodes 0x10 to 0x1F are information requests selected by data bits [3:0]: selector 2, 3 or 4 loads the readback word with auxiliary register of that number ANDed with 0x000FFFFF, selector 5 loads auxiliary register 5 ANDed with 0x003FFFFF, selector 7 loads the value 2, any other selector leaves the readback word unchanged.
- R10: A control write whose opcode lies in 0x02..0x0F, other than 0x05, and whose whole 32-bit value equals the last value accepted for that opcode is ignored: no state change and no pulse. After R1 or R2 the remembered value is 1 for opcode 0x03 and 0 for every other opcode.
- R11: `disp_dirty_o` is high for one cycle after an accepted write with opcode 0x00, 0x03, 0x05, 0x06, 0x07 or 0x08, and low after every other write or idle cycle.
- R12: A draw-setting write whose bits [31:27] are 11100 stores the whole word in auxiliary register bits [26:24]; any other draw-setting word is dropped, and an opcode 0x00 control write in the same cycle wins over it.
- R13: Every output changes only on the clock edge that follows a write strobe; with no strobe all registered outputs hold and both pulses are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr_en | input | 1 | Control word write strobe |
| ctl_wr_data | input | 32 | Control word, opcode in bits [31:24] |
| draw_wr_en | input | 1 | Draw-setting word write strobe |
| draw_wr_data | input | 32 | Draw-setting word |
| status_o | output | 32 | Status word |
| start_x_o | output | 10 | Scan-out origin X |
| start_y_o | output | 9 | Scan-out origin Y |
| h_beg_o | output | 12 | Horizontal window start |
| h_end_o | output | 12 | Horizontal window end |
| v_beg_o | output | 10 | Vertical window start |
| v_end_o | output | 10 | Vertical window end |
| rdback_o | output | 32 | Information readback word |
| disp_dirty_o | output | 1 | One-cycle visible-change pulse |
| framer_clr_o | output | 1 | One-cycle command framer clear pulse |

## Verification
The bench aims at the repeat filter: identical consecutive writes of opcode 0x06 must lose their dirty pulse while identical 0x05 writes keep it, and a design that filtered every opcode or none would show a wrong pulse. It probes the information request selectors at both mask widths and with an unused selector, where a design that cleared the readback or used one mask for all would return a wrong word. It also issues a soft reset together with a draw-setting write, where a design with the wrong priority would keep the new auxiliary value, and checks that opcode 0x01 pulses the framer without touching the status.

// File: rtl/disp_ctrl_pkg.sv
// Package: shared constants and opcode encoding for the display control decoder.
// Assumes a 32-bit control word with the opcode in the top byte.
package disp_ctrl_pkg;

    localparam int unsigned WORD_W = 32;

    // Status value after any reset
    localparam logic [WORD_W-1:0] STATUS_INIT = 32'h1480_2000;

    // Status bit positions that downstream logic decodes
    localparam int unsigned BLANK_BIT = 23;
    localparam int unsigned XFER_LSB  = 29;
    localparam int unsigned MODE_LSB  = 16;

    // Tag in bits [31:27] that marks a draw-setting word
    localparam logic [4:0] DRAW_TAG = 5'b11100;

    // Control opcodes
    typedef enum logic [7:0] {
        OP_FULL_RESET = 8'h00,
        OP_FRAMER_CLR = 8'h01,
        OP_BLANK      = 8'h03,
        OP_XFER_DIR   = 8'h04,
        OP_ORIGIN     = 8'h05,
        OP_HWINDOW    = 8'h06,
        OP_VWINDOW    = 8'h07,
        OP_MODE       = 8'h08
    } ctl_op_e;

    // Information request selectors
    localparam logic [3:0] SEL_NARROW_LO = 4'd2;
    localparam logic [3:0] SEL_NARROW_HI = 4'd4;
    localparam logic [3:0] SEL_WIDE      = 4'd5;
    localparam logic [3:0] SEL_VERSION   = 4'd7;
    localparam logic [WORD_W-1:0] VERSION_WORD = 32'd2;

endpackage

// File: rtl/disp_cmd_filter.sv
// Module: disp_cmd_filter
// Keeps the last accepted word for each low opcode and drops a write that
// repeats it (opcodes above 1, opcode 5 excepted). Assumes SHADOW_DEPTH is a
// power of two of at least 16 so every filtered opcode has an entry.
module disp_cmd_filter #(
    parameter int unsigned SHADOW_DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic        accept_o
);
    import disp_ctrl_pkg::*;

    localparam int unsigned IDX_W = $clog2(SHADOW_DEPTH);
    localparam logic [8:0]  DEPTH_LIM = 9'(SHADOW_DEPTH);
    localparam int unsigned BLANK_ENTRY = 3;

    logic [31:0]      shadow_q [SHADOW_DEPTH];
    logic [7:0]       op;
    logic [IDX_W-1:0] idx;
    logic             in_range;
    logic             repeat_hit;
    logic             soft_clr;

    // Split the incoming word into opcode and shadow index
    always_comb begin
        op       = wr_data[31:24];
        idx      = wr_data[24 +: IDX_W];
        in_range = ({1'b0, op} < DEPTH_LIM);
        soft_clr = wr_en && (op == OP_FULL_RESET);
    end

    // Decide whether the write repeats the stored value and is dropped
    always_comb begin
        repeat_hit = in_range && (op > 8'd1) && (op != OP_ORIGIN)
                     && (shadow_q[idx] == wr_data);
        accept_o   = wr_en && !repeat_hit;
    end

    // One storage entry per opcode; reset leaves the blank entry at 1
    for (genvar k = 0; k < SHADOW_DEPTH; k++) begin : g_shadow
        localparam logic [31:0] ENTRY_INIT = (k == BLANK_ENTRY) ? 32'd1 : 32'd0;

        // Hold the last accepted word for opcode k
        always_ff @(posedge clk) begin
            if (!rst_n || soft_clr) begin
                shadow_q[k] <= ENTRY_INIT;
            end else if (wr_en && in_range && (idx == IDX_W'(k))) begin
                shadow_q[k] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/disp_status_regs.sv
// Module: disp_status_regs
// Applies accepted control words to the status word and the display geometry
// fields, and produces the dirty and framer-clear pulses. Assumes cmd_valid_i
// already reflects the repeat filter.
module disp_status_regs #(
    parameter int unsigned SX_W = 10,
    parameter int unsigned SY_W = 9,
    parameter int unsigned HW_W = 12,
    parameter int unsigned VW_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid_i,
    input  logic [31:0]     cmd_word_i,
    output logic [31:0]     status_o,
    output logic [SX_W-1:0] start_x_o,
    output logic [SY_W-1:0] start_y_o,
    output logic [HW_W-1:0] h_beg_o,
    output logic [HW_W-1:0] h_end_o,
    output logic [VW_W-1:0] v_beg_o,
    output logic [VW_W-1:0] v_end_o,
    output logic            dirty_o,
    output logic            framer_clr_o
);
    import disp_ctrl_pkg::*;

    logic [7:0] op;
    logic       visible_op;
    logic       clear_op;

    // Classify the opcode for the two pulses
    always_comb begin
        op = cmd_word_i[31:24];
        visible_op = (op == OP_FULL_RESET) || (op == OP_BLANK) || (op == OP_ORIGIN)
                   || (op == OP_HWINDOW) || (op == OP_VWINDOW) || (op == OP_MODE);
        clear_op   = (op == OP_FULL_RESET) || (op == OP_FRAMER_CLR);
    end

    // Status word: blank bit, transfer direction and display mode fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_o <= STATUS_INIT;
        end else if (cmd_valid_i) begin
            case (op)
                OP_FULL_RESET: status_o <= STATUS_INIT;
                OP_BLANK:      status_o[BLANK_BIT] <= cmd_word_i[0];
                OP_XFER_DIR:   status_o[XFER_LSB +: 2] <= cmd_word_i[1:0];
                OP_MODE:       status_o[MODE_LSB +: 7] <= {cmd_word_i[5:0], cmd_word_i[6]};
                default:       status_o <= status_o;
            endcase
        end
    end

    // Scan-out origin
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_x_o <= '0;
            start_y_o <= '0;
        end else if (cmd_valid_i && (op == OP_FULL_RESET)) begin
            start_x_o <= '0;
            start_y_o <= '0;
        end else if (cmd_valid_i && (op == OP_ORIGIN)) begin
            start_x_o <= cmd_word_i[SX_W-1:0];
            start_y_o <= cmd_word_i[SX_W +: SY_W];
        end
    end

    // Horizontal display window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_beg_o <= '0;
            h_end_o <= '0;
        end else if (cmd_valid_i && (op == OP_FULL_RESET)) begin
            h_beg_o <= '0;
            h_end_o <= '0;
        end else if (cmd_valid_i && (op == OP_HWINDOW)) begin
            h_beg_o <= cmd_word_i[HW_W-1:0];
            h_end_o <= cmd_word_i[HW_W +: HW_W];
        end
    end

    // Vertical display window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_beg_o <= '0;
            v_end_o <= '0;
        end else if (cmd_valid_i && (op == OP_FULL_RESET)) begin
            v_beg_o <= '0;
            v_end_o <= '0;
        end else if (cmd_valid_i && (op == OP_VWINDOW)) begin
            v_beg_o <= cmd_word_i[VW_W-1:0];
            v_end_o <= cmd_word_i[VW_W +: VW_W];
        end
    end

    // One-cycle pulses toward scan-out and the command framer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dirty_o      <= 1'b0;
            framer_clr_o <= 1'b0;
        end else begin
            dirty_o      <= cmd_valid_i && visible_op;
            framer_clr_o <= cmd_valid_i && clear_op;
        end
    end

    AST_BLANK_FOLLOWS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && (op == OP_BLANK)) |=> (status_o[BLANK_BIT] == $past(cmd_word_i[0]))); // R4

    AST_XFER_FOLLOWS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && (op == OP_XFER_DIR)) |=> (status_o[30:29] == $past(cmd_word_i[1:0]))); // R5

    AST_MODE_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && (op == OP_MODE)) |=> (status_o[15:0] == $past(status_o[15:0]))); // R8

endmodule

// File: rtl/disp_aux_regs.sv
// Module: disp_aux_regs
// Holds the auxiliary draw-setting registers fed by the draw stream and the
// readback word loaded by information requests. Assumes AUX_CNT is 8 so the
// index in bits [26:24] covers every register.
module disp_aux_regs #(
    parameter int unsigned AUX_CNT  = 8,
    parameter int unsigned NARROW_W = 20,
    parameter int unsigned WIDE_W   = 22
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_clr_i,
    input  logic        draw_wr_en_i,
    input  logic [31:0] draw_wr_data_i,
    input  logic        info_req_i,
    input  logic [3:0]  info_sel_i,
    output logic [31:0] rdback_o
);
    import disp_ctrl_pkg::*;

    localparam int unsigned AUX_IDX_W   = $clog2(AUX_CNT);
    localparam logic [31:0] NARROW_MASK = (32'h1 << NARROW_W) - 32'h1;
    localparam logic [31:0] WIDE_MASK   = (32'h1 << WIDE_W) - 32'h1;

    logic [31:0]          aux_q [AUX_CNT];
    logic                 draw_hit;
    logic [AUX_IDX_W-1:0] draw_idx;
    logic [AUX_IDX_W-1:0] sel_idx;

    // Decode the draw-setting tag and target register
    always_comb begin
        draw_hit = draw_wr_en_i && (draw_wr_data_i[31:27] == DRAW_TAG);
        draw_idx = draw_wr_data_i[24 +: AUX_IDX_W];
        sel_idx  = info_sel_i[AUX_IDX_W-1:0];
    end

    // One auxiliary register per index; a soft reset beats a same-cycle write
    for (genvar j = 0; j < AUX_CNT; j++) begin : g_aux
        localparam logic [31:0] AUX_INIT = {8'(224 + j), 24'h0};

        // Hold draw-setting word j
        always_ff @(posedge clk) begin
            if (!rst_n || soft_clr_i) begin
                aux_q[j] <= AUX_INIT;
            end else if (draw_hit && (draw_idx == AUX_IDX_W'(j))) begin
                aux_q[j] <= draw_wr_data_i;
            end
        end
    end

    // Readback word: masked auxiliary value, constant, or hold
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr_i) begin
            rdback_o <= '0;
        end else if (info_req_i) begin
            if ((info_sel_i >= SEL_NARROW_LO) && (info_sel_i <= SEL_NARROW_HI)) begin
                rdback_o <= aux_q[sel_idx] & NARROW_MASK;
            end else if (info_sel_i == SEL_WIDE) begin
                rdback_o <= aux_q[sel_idx] & WIDE_MASK;
            end else if (info_sel_i == SEL_VERSION) begin
                rdback_o <= VERSION_WORD;
            end
        end
    end

    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (info_req_i && !soft_clr_i && (info_sel_i >= SEL_NARROW_LO) && (info_sel_i <= SEL_NARROW_HI))
        |=> ((rdback_o & ~NARROW_MASK) == 32'h0)); // R9

    AST_UNUSED_SEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (info_req_i && !soft_clr_i && ((info_sel_i < SEL_NARROW_LO) || (info_sel_i == 4'd6) || (info_sel_i > SEL_VERSION)))
        |=> $stable(rdback_o)); // R9

endmodule

// File: rtl/disp_ctrl_decoder.sv
// Module: disp_ctrl_decoder (top)
// Decodes display control words into status, geometry, readback and pulses,
// and accepts draw-setting words for the auxiliary registers. Assumes one
// control word per strobe; all outputs are registered.
module disp_ctrl_decoder #(
    parameter int unsigned SHADOW_DEPTH = 16,
    parameter int unsigned AUX_CNT      = 8,
    parameter int unsigned SX_W         = 10,
    parameter int unsigned SY_W         = 9,
    parameter int unsigned HW_W         = 12,
    parameter int unsigned VW_W         = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_wr_en,
    input  logic [31:0]     ctl_wr_data,
    input  logic            draw_wr_en,
    input  logic [31:0]     draw_wr_data,
    output logic [31:0]     status_o,
    output logic [SX_W-1:0] start_x_o,
    output logic [SY_W-1:0] start_y_o,
    output logic [HW_W-1:0] h_beg_o,
    output logic [HW_W-1:0] h_end_o,
    output logic [VW_W-1:0] v_beg_o,
    output logic [VW_W-1:0] v_end_o,
    output logic [31:0]     rdback_o,
    output logic            disp_dirty_o,
    output logic            framer_clr_o
);
    import disp_ctrl_pkg::*;

    logic accept;
    logic soft_clr;
    logic info_req;

    // Derive the soft reset and information request from the accepted word
    always_comb begin
        soft_clr = accept && (ctl_wr_data[31:24] == OP_FULL_RESET);
        info_req = accept && (ctl_wr_data[31:28] == 4'h1);
    end

    disp_cmd_filter #(
        .SHADOW_DEPTH (SHADOW_DEPTH)
    ) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ctl_wr_en),
        .wr_data  (ctl_wr_data),
        .accept_o (accept)
    );

    disp_status_regs #(
        .SX_W (SX_W),
        .SY_W (SY_W),
        .HW_W (HW_W),
        .VW_W (VW_W)
    ) u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid_i  (accept),
        .cmd_word_i   (ctl_wr_data),
        .status_o     (status_o),
        .start_x_o    (start_x_o),
        .start_y_o    (start_y_o),
        .h_beg_o      (h_beg_o),
        .h_end_o      (h_end_o),
        .v_beg_o      (v_beg_o),
        .v_end_o      (v_end_o),
        .dirty_o      (disp_dirty_o),
        .framer_clr_o (framer_clr_o)
    );

    disp_aux_regs #(
        .AUX_CNT (AUX_CNT)
    ) u_aux (
        .clk            (clk),
        .rst_n          (rst_n),
        .soft_clr_i     (soft_clr),
        .draw_wr_en_i   (draw_wr_en),
        .draw_wr_data_i (draw_wr_data),
        .info_req_i     (info_req),
        .info_sel_i     (ctl_wr_data[3:0]),
        .rdback_o       (rdback_o)
    );

    AST_FRAMER_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        framer_clr_o |-> $past(ctl_wr_en)); // R3

    AST_DIRTY_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        disp_dirty_o |-> $past(ctl_wr_en)); // R11

    AST_IDLE_HOLDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ctl_wr_en)) |-> $stable(status_o)); // R13

    AST_REPEAT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_en && !accept) |=> (!disp_dirty_o && $stable(status_o))); // R10

    AST_RESET_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (status_o == STATUS_INIT)); // R2

endmodule

// File: tb/disp_ctrl_decoder_test.sv
module disp_ctrl_decoder_test;

    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst_n;
    logic        ctl_wr_en;
    logic [31:0] ctl_wr_data;
    logic        draw_wr_en;
    logic [31:0] draw_wr_data;
    logic [31:0] status_o;
    logic [9:0]  start_x_o;
    logic [8:0]  start_y_o;
    logic [11:0] h_beg_o;
    logic [11:0] h_end_o;
    logic [9:0]  v_beg_o;
    logic [9:0]  v_end_o;
    logic [31:0] rdback_o;
    logic        disp_dirty_o;
    logic        framer_clr_o;

    disp_ctrl_decoder uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_wr_en    (ctl_wr_en),
        .ctl_wr_data  (ctl_wr_data),
        .draw_wr_en   (draw_wr_en),
        .draw_wr_data (draw_wr_data),
        .status_o     (status_o),
        .start_x_o    (start_x_o),
        .start_y_o    (start_y_o),
        .h_beg_o      (h_beg_o),
        .h_end_o      (h_end_o),
        .v_beg_o      (v_beg_o),
        .v_end_o      (v_end_o),
        .rdback_o     (rdback_o),
        .disp_dirty_o (disp_dirty_o),
        .framer_clr_o (framer_clr_o)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    // Reference model state
    logic [31:0] m_status, m_rd;
    logic [9:0]  m_sx;
    logic [8:0]  m_sy;
    logic [11:0] m_hb, m_he;
    logic [9:0]  m_vb, m_ve;
    logic [31:0] m_shadow [16];
    logic [31:0] m_aux [8];
    logic        m_dirty, m_fclr;
    logic [31:0] last_ctl;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "status", status_o, m_status);
        chk(req, "rdback", rdback_o, m_rd);
        chk(req, "start_x", 32'(start_x_o), 32'(m_sx));
        chk(req, "start_y", 32'(start_y_o), 32'(m_sy));
        chk(req, "h_beg", 32'(h_beg_o), 32'(m_hb));
        chk(req, "h_end", 32'(h_end_o), 32'(m_he));
        chk(req, "v_beg", 32'(v_beg_o), 32'(m_vb));
        chk(req, "v_end", 32'(v_end_o), 32'(m_ve));
        chk(req, "dirty", 32'(disp_dirty_o), 32'(m_dirty));
        chk(req, "framer_clr", 32'(framer_clr_o), 32'(m_fclr));
    endtask

    // R1 / R2 state
    task automatic model_reset();
        m_status = 32'h1480_2000;
        m_rd = 0; m_sx = 0; m_sy = 0; m_hb = 0; m_he = 0; m_vb = 0; m_ve = 0;
        for (int i = 0; i < 16; i++) m_shadow[i] = (i == 3) ? 32'd1 : 32'd0;
        for (int i = 0; i < 8; i++) m_aux[i] = {8'(224 + i), 24'h0};
    endtask

    task automatic model_ctl(input logic [31:0] d);
        logic [7:0] op;
        logic ign;
        op = d[31:24];
        m_dirty = 0; m_fclr = 0;
        ign = (op < 16) && (op > 1) && (op != 5) && (m_shadow[op[3:0]] == d);
        if (!ign) begin
            if (op < 16) m_shadow[op[3:0]] = d;
            case (op)
                8'h00: begin model_reset(); m_dirty = 1; m_fclr = 1; end
                8'h01: m_fclr = 1;
                8'h03: begin m_status[23] = d[0]; m_dirty = 1; end
                8'h04: m_status[30:29] = d[1:0];
                8'h05: begin m_sx = d[9:0]; m_sy = d[18:10]; m_dirty = 1; end
                8'h06: begin m_hb = d[11:0]; m_he = d[23:12]; m_dirty = 1; end
                8'h07: begin m_vb = d[9:0]; m_ve = d[19:10]; m_dirty = 1; end
                8'h08: begin m_status[22:16] = {d[5:0], d[6]}; m_dirty = 1; end
                default: begin
                    if (op[7:4] == 4'h1) begin
                        if (d[3:0] >= 2 && d[3:0] <= 4) m_rd = m_aux[d[2:0]] & 32'h000F_FFFF;
                        else if (d[3:0] == 5) m_rd = m_aux[5] & 32'h003F_FFFF;
                        else if (d[3:0] == 7) m_rd = 32'd2;
                    end
                end
            endcase
        end
    endtask

    function automatic string tag_of(input logic [31:0] d);
        case (d[31:24])
            8'h00: return "R2";
            8'h01: return "R3";
            8'h03: return "R4";
            8'h04: return "R5";
            8'h05: return "R6";
            8'h06, 8'h07: return "R7";
            8'h08: return "R8";
            default: return (d[31:28] == 4'h1) ? "R9" : "R11";
        endcase
    endfunction

    task automatic do_ctl(input logic [31:0] d, input string req);
        @(negedge clk);
        ctl_wr_en = 1; ctl_wr_data = d;
        @(negedge clk);
        ctl_wr_en = 0;
        model_ctl(d);
        last_ctl = d;
        check_all(req);
    endtask

    task automatic do_draw(input logic [31:0] d, input string req);
        @(negedge clk);
        draw_wr_en = 1; draw_wr_data = d;
        @(negedge clk);
        draw_wr_en = 0;
        if (d[31:27] == 5'b11100) m_aux[d[26:24]] = d;
        m_dirty = 0; m_fclr = 0;
        check_all(req);
    endtask

    task automatic do_idle(input string req);
        @(negedge clk);
        m_dirty = 0; m_fclr = 0;
        check_all(req);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [7:0] ops [12];
        ops = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h0C, 8'h10, 8'h1A, 8'h40};
        void'($urandom(32'd20240611));
        rst_n = 0; ctl_wr_en = 0; ctl_wr_data = 0; draw_wr_en = 0; draw_wr_data = 0;
        m_dirty = 0; m_fclr = 0; last_ctl = 0;
        model_reset();
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1;
        do_idle("R13");
        do_ctl(32'h1000_0002, "R1");        // aux 2 reinit masked -> 0

        // Directed corner cases
        do_ctl(32'h0100_0000, "R3");
        do_idle("R3");
        do_ctl(32'h0612_3456, "R7");
        do_ctl(32'h0612_3456, "R10");       // repeat: dropped, no pulse
        do_ctl(32'h0500_0000 | (32'd77 << 10) | 32'd300, "R6");
        do_ctl(32'h0500_0000 | (32'd77 << 10) | 32'd300, "R10"); // opcode 5 repeat still pulses
        do_ctl(32'h0300_0000, "R4");
        do_ctl(32'h0300_0001, "R4");
        do_ctl(32'h0400_0003, "R5");
        do_ctl(32'h0800_007F, "R8");
        do_ctl(32'h0800_0040, "R8");
        do_ctl(32'h070F_FFFF, "R7");
        do_draw(32'hE2AB_CDEF, "R12");
        do_draw(32'hD5FF_FFFF, "R12");      // wrong tag: dropped
        do_ctl(32'h1000_0005, "R12");       // aux 5 still at init
        do_draw(32'hE5FF_FFFF, "R12");
        do_ctl(32'h1000_0002, "R9");
        do_ctl(32'h1F00_0005, "R9");
        do_ctl(32'h1000_0000, "R9");        // unused selector holds
        do_ctl(32'h1000_0007, "R9");
        do_ctl(32'h0400_0000, "R11");

        // Soft reset colliding with a draw write: reset wins
        @(negedge clk);
        ctl_wr_en = 1; ctl_wr_data = 32'h0000_0000;
        draw_wr_en = 1; draw_wr_data = 32'hE4FF_FFFF;
        @(negedge clk);
        ctl_wr_en = 0; draw_wr_en = 0;
        model_ctl(32'h0000_0000);
        check_all("R12");
        do_ctl(32'h1000_0004, "R12");
        do_ctl(32'h0300_0001, "R10");       // blank shadow is 1 after reset
        do_ctl(32'h0400_0000, "R10");

        // Constrained random mix
        for (int it = 0; it < 600; it++) begin
            int r;
            r = int'($urandom % 20);
            if (r < 10) begin
                d = {ops[$urandom % 12], 24'($urandom)};
                if (d[31:24] == 8'h03 || d[31:24] == 8'h04) d[23:2] = 0;
                do_ctl(d, tag_of(d));
            end else if (r < 13) begin
                do_ctl(last_ctl, "R10");
            end else if (r < 16) begin
                d = $urandom;
                if (r != 15) d[31:27] = 5'b11100;
                do_draw(d, "R12");
            end else if (r < 18) begin
                d = {4'h1, 24'($urandom), 4'($urandom % 9)};
                do_ctl(d, "R9");
            end else if (r == 18) begin
                do_idle("R13");
            end else begin
                if (($urandom % 8) == 0) do_ctl(32'h0000_0000, "R2");
                else do_idle("R13");
            end
        end

        // Synchronous reset mid-run
        do_ctl(32'h0612_3457, "R7");
        @(negedge clk); rst_n = 0;
        @(negedge clk);
        model_reset(); m_dirty = 0; m_fclr = 0;
        check_all("R1");
        rst_n = 1;
        do_ctl(32'h0300_0001, "R10");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

endmodule